// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two bidirectional data buses, called A and B, through an 8-bit path in each direction. Each direction has its own holding register, loaded by its own capture strobe, and its own output enable. A per-direction select chooses what the driven side carries: live data taken straight from the opposite bus, or the value held in that direction's register. Each bus appears at the ports as a separate input, output and output-enable, so the block contains no internal tri-state nets. The surrounding logic resolves the physical bus.

The two enables have opposite polarities. The A-to-B enable is active high and drives bus B. The B-to-A enable is active low and drives bus A. The selects are registered, so a change between live and stored data takes effect at a clock edge and never shows a blend of the two sources. With both directions enabled in live mode, each output feeds back to its own input, so the pair holds its value once every other driver lets go. With both directions enabled in stored mode, the two registers are exchanged across the buses. A build parameter inverts the transferred data on every path.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both output enables are low whatever the control inputs. After reset, both registers hold zero.
- R2: On a clock edge with `cap_ab_i` high, the A-to-B register loads `a_i`. This happens regardless of the enables and selects. With `cap_ab_i` low, the register keeps its value.
- R3: On a clock edge with `cap_ba_i` high, the B-to-A register loads `b_i`. This happens regardless of the enables and selects. With `cap_ba_i` low, the register keeps its value.
- R4: Outside reset, `b_oe_o` equals `oe_ab_i` (active high) and `a_oe_o` equals the inverse of `oe_ba_n_i` (active low). Each bus can be isolated on its own or both together.
- R5: When a select has been low at the last clock edge, the driven output carries the opposite bus input in the same cycle, combinationally.
- R6: A select change takes effect at the next clock edge. A select high at that edge makes the output carry the register value, and later changes on the live input do not affect it. The output is always either the live value or the stored value.
- R7: With both enables on and both selects high, bus B carries the A-to-B register and bus A carries the B-to-A register at the same time.
- R8: With both enables on and both selects low, the two buses hold their last value after every external driver is released.
- R9: While bus A drives bus B live, one edge with both capture strobes high loads the same value into both registers.
- R10: With `INVERT` = 1, every transferred value (live or stored) is the bitwise complement of its source. The default `INVERT` = 0 passes data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both registers and the select stages |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_i | input | WIDTH | Value seen on bus A |
| a_o | output | WIDTH | Value the block drives onto bus A |
| a_oe_o | output | 1 | High when the block drives bus A |
| b_i | input | WIDTH | Value seen on bus B |
| b_o | output | WIDTH | Value the block drives onto bus B |
| b_oe_o | output | 1 | High when the block drives bus B |
| oe_ab_i | input | 1 | Active-high enable for driving bus B |
| oe_ba_n_i | input | 1 | Active-low enable for driving bus A |
| sel_ab_i | input | 1 | Source for bus B: 0 live A, 1 stored |
| sel_ba_i | input | 1 | Source for bus A: 0 live B, 1 stored |
| cap_ab_i | input | 1 | Load bus A into the A-to-B register at the clock edge |
| cap_ba_i | input | 1 | Load bus B into the B-to-A register at the clock edge |

## Verification
A wrong register value stays hidden until a stored-mode read. The bench therefore reads both registers across the buses two cycles after every load, with the buses changed in between, so a missed load or a spurious reload shows as a wrong byte at once. A stuck or mis-timed select stage shows up within one cycle of a select change as the wrong source on the driven bus. Inverted data or a swapped enable polarity shows up in the same cycle as the live sweeps.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } xcvr_src_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             sel_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] store_o,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] store_q, store_d;
  xcvr_src_e        src_q, src_d;
  logic [WIDTH-1:0] picked;

  // next state: load on capture, otherwise hold; select sampled every edge
  always_comb begin
    store_d = store_q;
    if (cap_i) begin
      store_d = data_i;
    end
    src_d = sel_i ? SRC_STORED : SRC_LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      src_q   <= SRC_LIVE;
    end else begin
      store_q <= store_d;
      src_q   <= src_d;
    end
  end

  // the mux only switches at an edge, between two settled sources
  always_comb begin
    picked = (src_q == SRC_STORED) ? store_q : data_i;
  end

  generate
    if (INVERT) begin : g_inv
      assign out_o = ~picked;
    end else begin : g_true
      assign out_o = picked;
    end
  endgenerate

  assign store_o = store_q;
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int WIDTH       = 8,
  parameter bit INVERT      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o,
  input  logic             oe_ab_i,
  input  logic             oe_ba_n_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             cap_ab_i,
  input  logic             cap_ba_i
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] store_ab;
  logic [WIDTH-1:0] store_ba;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // A to B direction: loads bus A, drives bus B
  xcvr_lane #(.WIDTH(WIDTH), .INVERT(INVERT)) u_lane_ab (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap_i   (cap_ab_i),
    .sel_i   (sel_ab_i),
    .data_i  (a_i),
    .store_o (store_ab),
    .out_o   (b_o)
  );

  // B to A direction: loads bus B, drives bus A
  xcvr_lane #(.WIDTH(WIDTH), .INVERT(INVERT)) u_lane_ba (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap_i   (cap_ba_i),
    .sel_i   (sel_ba_i),
    .data_i  (b_i),
    .store_o (store_ba),
    .out_o   (a_o)
  );

  // enables are gated off for as long as the synchronized reset is held
  assign b_oe_o = rst_sync_n & oe_ab_i;
  assign a_oe_o = rst_sync_n & ~oe_ba_n_i;
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe_o,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe_o,
  input logic             oe_ab_i,
  input logic             oe_ba_n_i,
  input logic             sel_ab_i,
  input logic             sel_ba_i,
  input logic             cap_ab_i,
  input logic             cap_ba_i,
  input logic [WIDTH-1:0] store_ab,
  input logic [WIDTH-1:0] store_ba
);
  function automatic logic [WIDTH-1:0] xf(input logic [WIDTH-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      assert_oe_off_in_reset_R1: assert (!a_oe_o && !b_oe_o);
    end
  end

  assert_load_ab_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_ab_i |=> (store_ab == $past(a_i)));
  assert_hold_ab_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_ab_i |=> $stable(store_ab));
  assert_load_ba_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_ba_i |=> (store_ba == $past(b_i)));
  assert_hold_ba_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_ba_i |=> $stable(store_ba));

  assert_oe_polarity_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (b_oe_o == oe_ab_i) && (a_oe_o == !oe_ba_n_i));

  assert_live_b_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sel_ab_i && !$past(sel_ab_i)) |-> (b_o == xf(a_i)));
  assert_live_a_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sel_ba_i && !$past(sel_ba_i)) |-> (a_o == xf(b_i)));

  assert_stored_b_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_ab_i && $past(sel_ab_i) && $past(rst_sync_n)) |-> (b_o == xf(store_ab)));
  assert_stored_a_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_ba_i && $past(sel_ba_i) && $past(rst_sync_n)) |-> (a_o == xf(store_ba)));
  assert_no_blend_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((b_o == xf(a_i)) || (b_o == xf(store_ab))) && ((a_o == xf(b_i)) || (a_o == xf(store_ba))));
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .a_i        (a_i),
  .a_o        (a_o),
  .a_oe_o     (a_oe_o),
  .b_i        (b_i),
  .b_o        (b_o),
  .b_oe_o     (b_oe_o),
  .oe_ab_i    (oe_ab_i),
  .oe_ba_n_i  (oe_ba_n_i),
  .sel_ab_i   (sel_ab_i),
  .sel_ba_i   (sel_ba_i),
  .cap_ab_i   (cap_ab_i),
  .cap_ba_i   (cap_ba_i),
  .store_ab   (store_ab),
  .store_ba   (store_ba)
);

// File: tb/test_reg_bus_xcvr.sv
`timescale 1ns/1ps
module test_reg_bus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [W-1:0] ext_a, ext_b;
  logic         ext_a_en, ext_b_en;
  logic         oe_ab, oe_ba_n, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [W-1:0] a_o, b_o, a_bus, b_bus, a_seen, b_seen;
  logic         a_oe, b_oe;

  // bus resolution: block drive, else external driver, else last value
  assign a_bus = a_oe ? a_o : (ext_a_en ? ext_a : a_seen);
  assign b_bus = b_oe ? b_o : (ext_b_en ? ext_b : b_seen);
  assign #1 a_seen = a_bus;
  assign #1 b_seen = b_bus;

  reg_bus_xcvr i_reg_bus_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_i(a_seen), .a_o(a_o), .a_oe_o(a_oe),
    .b_i(b_seen), .b_o(b_o), .b_oe_o(b_oe),
    .oe_ab_i(oe_ab), .oe_ba_n_i(oe_ba_n),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .cap_ab_i(cap_ab), .cap_ba_i(cap_ba)
  );

  logic [W-1:0] inv_a, inv_b, inv_a_o, inv_b_o;
  logic         inv_sel, inv_cap, inv_a_oe, inv_b_oe;

  reg_bus_xcvr #(.INVERT(1'b1)) i_reg_bus_xcvr_inv (
    .clk(clk), .rst_n(rst_n),
    .a_i(inv_a), .a_o(inv_a_o), .a_oe_o(inv_a_oe),
    .b_i(inv_b), .b_o(inv_b_o), .b_oe_o(inv_b_oe),
    .oe_ab_i(1'b1), .oe_ba_n_i(1'b0),
    .sel_ab_i(inv_sel), .sel_ba_i(1'b0),
    .cap_ab_i(inv_cap), .cap_ba_i(1'b0)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic isolate();
    oe_ab = 1'b0; oe_ba_n = 1'b1; ext_a_en = 1'b1; ext_b_en = 1'b1;
  endtask

  task automatic read_stores(input logic [W-1:0] exp_ab, input logic [W-1:0] exp_ba,
                             input string req_ab, input string req_ba);
    ext_a_en = 1'b0; ext_b_en = 1'b0; cap_ab = 1'b0; cap_ba = 1'b0;
    sel_ab = 1'b1; sel_ba = 1'b1; oe_ab = 1'b1; oe_ba_n = 1'b0;
    tick();
    chk(req_ab, b_bus, exp_ab);
    chk(req_ba, a_bus, exp_ba);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] va, vb, w;
    rst_n = 1'b0;
    ext_a = 8'hAA; ext_b = 8'h55; ext_a_en = 1'b1; ext_b_en = 1'b1;
    oe_ab = 1'b1; oe_ba_n = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    cap_ab = 1'b1; cap_ba = 1'b1;
    inv_a = '0; inv_b = '0; inv_sel = 1'b0; inv_cap = 1'b0;
    va = '0; vb = '0; w = '0;

    // R1: enables forced off in reset even though requested
    repeat (3) tick();
    chk("R1 a_oe in reset", {7'b0, a_oe}, 8'h00);
    chk("R1 b_oe in reset", {7'b0, b_oe}, 8'h00);
    isolate();
    cap_ab = 1'b0; cap_ba = 1'b0;
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: both registers zero after reset, R7 exchange with zero
    read_stores(8'h00, 8'h00, "R1 store_ab zero", "R1 store_ba zero");

    // R4: enable polarities and isolation
    oe_ab = 1'b0; oe_ba_n = 1'b1; #2;
    chk("R4 full isolation", {6'b0, a_oe, b_oe}, 8'h00);
    oe_ba_n = 1'b0; #2;
    chk("R4 drive A only", {6'b0, a_oe, b_oe}, 8'h02);
    oe_ab = 1'b1; oe_ba_n = 1'b1; #2;
    chk("R4 drive B only", {6'b0, a_oe, b_oe}, 8'h01);
    isolate();
    sel_ab = 1'b0; sel_ba = 1'b0;
    tick();

    // R5: live sweep A to B
    oe_ab = 1'b1; ext_b_en = 1'b0;
    for (int v = 0; v < 256; v++) begin
      ext_a = v[W-1:0]; #2;
      chk("R5 live A to B", b_bus, v[W-1:0]);
    end
    // R5: live sweep B to A
    oe_ab = 1'b0; ext_b_en = 1'b1; ext_a_en = 1'b0; oe_ba_n = 1'b0;
    for (int v = 0; v < 256; v++) begin
      ext_b = v[W-1:0]; #2;
      chk("R5 live B to A", a_bus, v[W-1:0]);
    end
    isolate();
    tick();

    // R2 R3: loads with enables off, then hold with capture low, then read back (R7)
    for (int i = 0; i < 16; i++) begin
      va = (i * 17) ^ 8'h5C;
      vb = ~va + i[W-1:0];
      isolate();
      sel_ab = i[0]; sel_ba = i[1];
      ext_a = va; ext_b = vb; cap_ab = 1'b1; cap_ba = 1'b1;
      tick();
      cap_ab = 1'b0; cap_ba = 1'b0; ext_a = ~va; ext_b = ~vb;
      tick();
      read_stores(va, vb, "R2 A register", "R3 B register");
    end
    chk("R7 both buses driven", {6'b0, a_oe, b_oe}, 8'h03);
    chk("R7 stored A on bus B", b_bus, va);

    // R6: select takes effect at next edge; stored value ignores live changes
    isolate();
    sel_ab = 1'b0; sel_ba = 1'b0;
    w = va ^ 8'hFF;
    ext_a = w; ext_b_en = 1'b0; oe_ab = 1'b1;
    tick();
    chk("R6 live before switch", b_bus, w);
    sel_ab = 1'b1; #2;
    chk("R6 still live before edge", b_bus, w);
    tick();
    chk("R6 stored after edge", b_bus, va);
    ext_a = 8'h11; #2;
    chk("R6 stored ignores live", b_bus, va);
    sel_ab = 1'b0; #2;
    chk("R6 stored until edge", b_bus, va);
    tick();
    chk("R6 live after edge", b_bus, 8'h11);

    // R9: A drives B live, both registers loaded on one edge
    ext_a = 8'h3C; cap_ab = 1'b1; cap_ba = 1'b1;
    tick();
    read_stores(8'h3C, 8'h3C, "R9 A register", "R9 B register");

    // R8: both enabled live, hold after external release
    isolate();
    sel_ab = 1'b0; sel_ba = 1'b0;
    ext_a_en = 1'b0; oe_ba_n = 1'b0; ext_b = 8'hC3;
    tick();
    chk("R8 A follows B", a_bus, 8'hC3);
    oe_ab = 1'b1; ext_b_en = 1'b0;
    repeat (3) tick();
    chk("R8 A holds", a_bus, 8'hC3);
    chk("R8 B holds", b_bus, 8'hC3);
    isolate();
    tick();

    // R10: inverting variant, live and stored
    for (int v = 0; v < 256; v++) begin
      inv_a = v[W-1:0]; #2;
      chk("R10 inverted live", inv_b_o, ~v[W-1:0]);
    end
    inv_b = 8'h81; #2;
    chk("R10 inverted live B to A", inv_a_o, 8'h7E);
    inv_a = 8'h0F; inv_cap = 1'b1;
    tick();
    inv_cap = 1'b0; inv_sel = 1'b1; inv_a = 8'h00;
    tick();
    chk("R10 inverted stored", inv_b_o, 8'hF0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule